// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Hazard Control

This block sits beside the decode stage of a five-stage in-order integer pipeline. It settles a branch-if-equal instruction while that instruction is still in decode. Two forwarding multiplexers sit after the register-file read ports and supply current operands to a dedicated equality comparator; no subtract-and-zero-test is used. A separate adder produces the branch target. None of the branch information travels into the execute stage, so the branch retires in decode.

The same block produces the operand-source selects for the execute stage. It also produces the stall enables for fetch and decode, the bubble that goes into the decode/execute register, and the flush of the fetch/decode register when a branch is taken. It holds the fetch program counter and moves it each cycle. The ALU, the memories and the register file live outside. An early branch decision needs its operands one stage sooner than the ALU does, so the block adds decode-time read-after-write stalls on top of the usual load-use stall.

Top module: `dec_branch_hazard`

## Requirements
- R1: While `rst_n` is low, `pc_f` equals `RESET_PC`. In a cycle with no stall and no taken branch, `pc_f` grows by 4 at the next clock edge.
- R2: `branch_tgt_d` is always `id_pc_plus4 + (id_imm << 2)`. When `id_branch` is high, no stall is raised and the two decode operands are equal, `pc_src_d` and `flush_d` are 1 and `pc_f` takes `branch_tgt_d` at the next edge.
- R3: A branch whose decode operands differ sets `pc_src_d` and `flush_d` to 0, and `pc_f` grows by 4.
- R4: Each decode operand comes from the MEM-stage value when `mem_regwrite` is high, `mem_memread` is low and `mem_rd` equals the source. Otherwise it comes from the WB value when `wb_regwrite` is high and `wb_rd` matches. Otherwise it is the register-file value. The MEM match wins when both match.
- R5: `fwd_a_e` and `fwd_b_e` (for `ex_rs` and `ex_rt`) use the encoding 2'b10 = MEM result, 2'b01 = WB result, 2'b00 = register file. MEM applies when `mem_regwrite` is high and `mem_rd` matches, and it takes priority over a WB match.
- R6: Register number 0 is never a forwarding source, in decode or in execute. A producer writing register 0 never causes a stall.
- R7: When `ex_memread` is high and a nonzero `ex_rd` equals `id_rs` or `id_rt`, `stall_f`, `stall_d` and `flush_e` are all 1.
- R8: A branch in decode whose source equals a nonzero `ex_rd` with `ex_regwrite` high stalls for that cycle. While stalled, `pc_src_d` and `flush_d` stay 0.
- R9: A branch in decode whose source equals a nonzero `mem_rd` with `mem_memread` high stalls. A load that is in EX when the branch first reaches decode therefore costs two stall cycles. A non-branch consumer of a load in MEM does not stall.
- R10: In any stalled cycle, `pc_f` keeps its value across the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_branch | input | 1 | Instruction in decode is a branch-if-equal |
| id_rs | input | AW | First source register number in decode |
| id_rt | input | AW | Second source register number in decode |
| id_rs_val | input | DW | Register-file value read for id_rs |
| id_rt_val | input | DW | Register-file value read for id_rt |
| id_pc_plus4 | input | DW | Address after the decode instruction |
| id_imm | input | DW | Sign-extended word offset of the branch |
| ex_rs | input | AW | First source register in execute |
| ex_rt | input | AW | Second source register in execute |
| ex_rd | input | AW | Destination register in execute |
| ex_regwrite | input | 1 | Execute instruction writes a register |
| ex_memread | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register in memory stage |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| mem_val | input | DW | ALU result held in the memory stage |
| wb_rd | input | AW | Destination register in write-back |
| wb_regwrite | input | 1 | Write-back instruction writes a register |
| wb_val | input | DW | Value being written back |
| pc_f | output | DW | Fetch program counter |
| pc_src_d | output | 1 | Next PC is the branch target |
| branch_tgt_d | output | DW | Branch target computed in decode |
| stall_f | output | 1 | Hold the program counter |
| stall_d | output | 1 | Hold the fetch/decode register |
| flush_d | output | 1 | Clear the fetch/decode register to a bubble |
| flush_e | output | 1 | Insert a bubble into decode/execute |
| fwd_a_e | output | 2 | Operand source select for ex_rs |
| fwd_b_e | output | 2 | Operand source select for ex_rt |

## Verification
The checks assume the pipeline gives consistent stage flags. A load always has its register-write flag set as well, and a stage with no write carries no meaningful destination. The stimulus builds every cycle as a coherent pipeline snapshot. Multi-cycle hazards are walked stage by stage, with the producer advancing from EX to MEM to WB while the decode fields stay put, just as they would behind a stall.

// File: rtl/bhz_pkg.sv
package bhz_pkg;
  // Operand source encoding shared by decode and execute forwarding
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/bhz_fwd_pick.sv
module bhz_fwd_pick #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]     src,
  input  logic [AW-1:0]     mem_rd,
  input  logic              mem_we,
  input  logic [AW-1:0]     wb_rd,
  input  logic              wb_we,
  output bhz_pkg::fwd_sel_e sel
);
  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = (src != '0);
    mem_hit  = src_live && mem_we && (mem_rd == src);
    wb_hit   = src_live && wb_we && (wb_rd == src);
    if (mem_hit)     sel = bhz_pkg::FWD_MEM;
    else if (wb_hit) sel = bhz_pkg::FWD_WB;
    else             sel = bhz_pkg::FWD_RF;
  end
endmodule

// File: rtl/bhz_dec_resolve.sv
module bhz_dec_resolve #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     rs_val,
  input  logic [DW-1:0]     rt_val,
  input  bhz_pkg::fwd_sel_e sel_a,
  input  bhz_pkg::fwd_sel_e sel_b,
  input  logic [DW-1:0]     mem_val,
  input  logic [DW-1:0]     wb_val,
  input  logic [DW-1:0]     pc_plus4,
  input  logic [DW-1:0]     imm,
  output logic              equal,
  output logic [DW-1:0]     target
);
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] opnd_b;

  function automatic logic [DW-1:0] pick_val(bhz_pkg::fwd_sel_e s, logic [DW-1:0] rf,
                                             logic [DW-1:0] m, logic [DW-1:0] w);
    case (s)
      bhz_pkg::FWD_MEM: pick_val = m;
      bhz_pkg::FWD_WB:  pick_val = w;
      default:          pick_val = rf;
    endcase
  endfunction

  always_comb begin
    opnd_a = pick_val(sel_a, rs_val, mem_val, wb_val);
    opnd_b = pick_val(sel_b, rt_val, mem_val, wb_val);
    equal  = (opnd_a == opnd_b);
    target = pc_plus4 + {imm[DW-3:0], 2'b00};
  end
endmodule

// File: rtl/bhz_stall_ctl.sv
module bhz_stall_ctl #(
  parameter int AW = 5
) (
  input  logic          id_branch,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_regwrite,
  input  logic          ex_memread,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_memread,
  output logic          stall
);
  logic ex_hit;
  logic mem_hit;
  logic load_use;
  logic br_wait_ex;
  logic br_wait_mem;

  always_comb begin
    ex_hit      = (ex_rd != '0) && ((ex_rd == id_rs) || (ex_rd == id_rt));
    mem_hit     = (mem_rd != '0) && ((mem_rd == id_rs) || (mem_rd == id_rt));
    load_use    = ex_memread && ex_hit;
    br_wait_ex  = id_branch && ex_regwrite && ex_hit;
    br_wait_mem = id_branch && mem_memread && mem_hit;
    stall       = load_use || br_wait_ex || br_wait_mem;
  end
endmodule

// File: rtl/bhz_pc_reg.sv
module bhz_pc_reg #(
  parameter int             DW       = 32,
  parameter logic [DW-1:0]  RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          take,
  input  logic [DW-1:0] target,
  output logic [DW-1:0] pc
);
  localparam logic [DW-1:0] STEP = DW'(4);

  logic [DW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    pc_en = !hold;
    pc_d  = take ? target : (pc + STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= RESET_PC;
    else if (pc_en) pc <= pc_d;
  end
endmodule

// File: rtl/dec_branch_hazard.sv
module dec_branch_hazard #(
  parameter int             DW       = 32,
  parameter int             AW       = 5,
  parameter logic [DW-1:0]  RESET_PC = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_branch,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [DW-1:0] id_rs_val,
  input  logic [DW-1:0] id_rt_val,
  input  logic [DW-1:0] id_pc_plus4,
  input  logic [DW-1:0] id_imm,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_regwrite,
  input  logic          ex_memread,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwrite,
  input  logic          mem_memread,
  input  logic [DW-1:0] mem_val,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_regwrite,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] pc_f,
  output logic          pc_src_d,
  output logic [DW-1:0] branch_tgt_d,
  output logic          stall_f,
  output logic          stall_d,
  output logic          flush_d,
  output logic          flush_e,
  output logic [1:0]    fwd_a_e,
  output logic [1:0]    fwd_b_e
);
  localparam int NOPS = 2;

  logic [AW-1:0]     dec_src [NOPS];
  logic [AW-1:0]     ex_src  [NOPS];
  bhz_pkg::fwd_sel_e dec_sel [NOPS];
  bhz_pkg::fwd_sel_e ex_sel  [NOPS];
  logic              mem_alu_we;
  logic              ops_equal;
  logic              hazard;
  logic              take;

  assign dec_src[0] = id_rs;
  assign dec_src[1] = id_rt;
  assign ex_src[0]  = ex_rs;
  assign ex_src[1]  = ex_rt;
  // a load in MEM has no data yet, so only ALU results feed the comparator
  assign mem_alu_we = mem_regwrite && !mem_memread;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    bhz_fwd_pick #(.AW(AW)) u_dec_pick (
      .src(dec_src[g]), .mem_rd(mem_rd), .mem_we(mem_alu_we),
      .wb_rd(wb_rd), .wb_we(wb_regwrite), .sel(dec_sel[g])
    );
    bhz_fwd_pick #(.AW(AW)) u_ex_pick (
      .src(ex_src[g]), .mem_rd(mem_rd), .mem_we(mem_regwrite),
      .wb_rd(wb_rd), .wb_we(wb_regwrite), .sel(ex_sel[g])
    );
  end

  bhz_dec_resolve #(.DW(DW)) u_resolve (
    .rs_val(id_rs_val), .rt_val(id_rt_val),
    .sel_a(dec_sel[0]), .sel_b(dec_sel[1]),
    .mem_val(mem_val), .wb_val(wb_val),
    .pc_plus4(id_pc_plus4), .imm(id_imm),
    .equal(ops_equal), .target(branch_tgt_d)
  );

  bhz_stall_ctl #(.AW(AW)) u_stall (
    .id_branch(id_branch), .id_rs(id_rs), .id_rt(id_rt),
    .ex_rd(ex_rd), .ex_regwrite(ex_regwrite), .ex_memread(ex_memread),
    .mem_rd(mem_rd), .mem_memread(mem_memread), .stall(hazard)
  );

  assign take = id_branch && ops_equal && !hazard;

  bhz_pc_reg #(.DW(DW), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .hold(hazard), .take(take),
    .target(branch_tgt_d), .pc(pc_f)
  );

  always_comb begin
    pc_src_d = take;
    flush_d  = take;
    stall_f  = hazard;
    stall_d  = hazard;
    flush_e  = hazard;
    fwd_a_e  = ex_sel[0];
    fwd_b_e  = ex_sel[1];
  end
endmodule

// File: rtl/bhz_checker.sv
module bhz_checker #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          id_branch,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic [AW-1:0] ex_rd,
  input logic          ex_memread,
  input logic [AW-1:0] mem_rd,
  input logic          mem_regwrite,
  input logic          mem_memread,
  input logic [DW-1:0] pc_f,
  input logic          pc_src_d,
  input logic [DW-1:0] branch_tgt_d,
  input logic          stall_f,
  input logic          stall_d,
  input logic [1:0]    fwd_a_e,
  input logic [1:0]    fwd_b_e
);
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_f && !pc_src_d) |=> (pc_f == $past(pc_f) + DW'(4)));

  assert_take_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src_d |=> (pc_f == $past(branch_tgt_d)));

  assert_mem_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_e == 2'b10) |-> (mem_regwrite && mem_rd == ex_rs));

  assert_zero_src_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_e != 2'b00) |-> (ex_rs != '0));

  assert_zero_src_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_e != 2'b00) |-> (ex_rt != '0));

  assert_load_use_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_memread && ex_rd != '0 && (ex_rd == id_rs || ex_rd == id_rt)) |-> stall_d);

  assert_no_take_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_d |-> !pc_src_d);

  assert_branch_mem_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && mem_memread && mem_rd != '0 && (mem_rd == id_rs || mem_rd == id_rt))
      |-> stall_d);

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_f |=> (pc_f == $past(pc_f)));
endmodule

bind dec_branch_hazard bhz_checker #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/dec_branch_hazard_tb.sv
`timescale 1ns/1ps
module dec_branch_hazard_tb;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [DW-1:0] RST_PC = 32'h100;

  typedef struct {
    logic br; logic [AW-1:0] rs, rt; logic [DW-1:0] rsv, rtv, pc4, imm;
    logic [AW-1:0] exrs, exrt, exrd; logic exwe, exld;
    logic [AW-1:0] memrd; logic memwe, memld; logic [DW-1:0] memv;
    logic [AW-1:0] wbrd; logic wbwe; logic [DW-1:0] wbv;
  } stim_t;

  typedef struct {
    string req; logic take, stall; logic [1:0] fa, fb;
    logic [DW-1:0] tgt, pc;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic id_branch, ex_regwrite, ex_memread, mem_regwrite, mem_memread, wb_regwrite;
  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic [DW-1:0] id_rs_val, id_rt_val, id_pc_plus4, id_imm, mem_val, wb_val;
  logic [DW-1:0] pc_f, branch_tgt_d;
  logic pc_src_d, stall_f, stall_d, flush_d, flush_e;
  logic [1:0] fwd_a_e, fwd_b_e;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  logic [DW-1:0] mpc;

  always #2 clk = ~clk;

  dec_branch_hazard #(.DW(DW), .AW(AW), .RESET_PC(RST_PC)) u_dut (.*);

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic stim_t idle();
    stim_t s;
    s.br = 0; s.rs = 0; s.rt = 0; s.rsv = 0; s.rtv = 0; s.pc4 = 32'h2000; s.imm = 0;
    s.exrs = 0; s.exrt = 0; s.exrd = 0; s.exwe = 0; s.exld = 0;
    s.memrd = 0; s.memwe = 0; s.memld = 0; s.memv = 0;
    s.wbrd = 0; s.wbwe = 0; s.wbv = 0;
    return s;
  endfunction

  function automatic logic [1:0] fsel(logic [AW-1:0] src, logic [AW-1:0] mrd, logic mwe,
                                      logic [AW-1:0] wrd, logic wwe);
    if (src != 0 && mwe && mrd == src) return 2'b10;
    if (src != 0 && wwe && wrd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] dval(logic [1:0] s, logic [DW-1:0] rf, stim_t t);
    return (s == 2'b10) ? t.memv : (s == 2'b01) ? t.wbv : rf;
  endfunction

  task automatic step(string req, stim_t s);
    exp_t e;
    logic [DW-1:0] a, b;
    logic hit_ex, hit_mem;
    id_branch = s.br; id_rs = s.rs; id_rt = s.rt; id_rs_val = s.rsv; id_rt_val = s.rtv;
    id_pc_plus4 = s.pc4; id_imm = s.imm; ex_rs = s.exrs; ex_rt = s.exrt; ex_rd = s.exrd;
    ex_regwrite = s.exwe; ex_memread = s.exld; mem_rd = s.memrd; mem_regwrite = s.memwe;
    mem_memread = s.memld; mem_val = s.memv; wb_rd = s.wbrd; wb_regwrite = s.wbwe;
    wb_val = s.wbv;
    a = dval(fsel(s.rs, s.memrd, s.memwe && !s.memld, s.wbrd, s.wbwe), s.rsv, s);
    b = dval(fsel(s.rt, s.memrd, s.memwe && !s.memld, s.wbrd, s.wbwe), s.rtv, s);
    hit_ex  = s.exrd != 0 && (s.exrd == s.rs || s.exrd == s.rt);
    hit_mem = s.memrd != 0 && (s.memrd == s.rs || s.memrd == s.rt);
    e.req   = req;
    e.stall = (s.exld && hit_ex) || (s.br && s.exwe && hit_ex) || (s.br && s.memld && hit_mem);
    e.take  = s.br && !e.stall && (a == b);
    e.fa    = fsel(s.exrs, s.memrd, s.memwe, s.wbrd, s.wbwe);
    e.fb    = fsel(s.exrt, s.memrd, s.memwe, s.wbrd, s.wbwe);
    e.tgt   = s.pc4 + (s.imm << 2);
    e.pc    = e.stall ? mpc : e.take ? e.tgt : mpc + 4;
    mpc     = e.pc;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: comb outputs still reflect this cycle's inputs, pc_f has just updated
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "pc_src_d", pc_src_d, e.take);
        chk(e.req, "flush_d", flush_d, e.take);
        chk(e.req, "stall_f", stall_f, e.stall);
        chk(e.req, "stall_d", stall_d, e.stall);
        chk(e.req, "flush_e", flush_e, e.stall);
        chk(e.req, "fwd_a_e", fwd_a_e, e.fa);
        chk(e.req, "fwd_b_e", fwd_b_e, e.fb);
        chk(e.req, "branch_tgt_d", branch_tgt_d, e.tgt);
        chk(e.req, "pc_f", pc_f, e.pc);
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    stim_t s;
    s = idle();
    id_branch = 0; id_rs = 0; id_rt = 0; id_rs_val = 0; id_rt_val = 0; id_pc_plus4 = 0;
    id_imm = 0; ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_regwrite = 0; ex_memread = 0;
    mem_rd = 0; mem_regwrite = 0; mem_memread = 0; mem_val = 0; wb_rd = 0;
    wb_regwrite = 0; wb_val = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset pc_f", pc_f, RST_PC);
    mpc = RST_PC;
    rst_n = 1;

    step("R1", idle());
    step("R1", idle());

    // R2: equal register-file operands, taken
    s = idle(); s.br = 1; s.rs = 1; s.rt = 2; s.rsv = 42; s.rtv = 42; s.imm = 32'hFFFF_FFF0;
    step("R2", s);
    // R3: operands differ
    s = idle(); s.br = 1; s.rs = 1; s.rt = 2; s.rsv = 1; s.rtv = 2; s.imm = 8;
    step("R3", s);
    // R4: MEM ALU value forwarded makes operands equal
    s = idle(); s.br = 1; s.rs = 3; s.rt = 4; s.rsv = 0; s.rtv = 77; s.imm = 5;
    s.memrd = 3; s.memwe = 1; s.memv = 77;
    step("R4", s);
    // R4: MEM beats WB on the same register
    s = idle(); s.br = 1; s.rs = 3; s.rt = 4; s.rsv = 0; s.rtv = 77; s.imm = 6;
    s.memrd = 3; s.memwe = 1; s.memv = 77; s.wbrd = 3; s.wbwe = 1; s.wbv = 5;
    step("R4", s);
    // R4: WB only
    s = idle(); s.br = 1; s.rs = 3; s.rt = 4; s.rsv = 0; s.rtv = 9; s.imm = 2;
    s.wbrd = 4; s.wbwe = 1; s.wbv = 0;
    step("R4", s);
    // R5: EX selects, MEM on rs, WB on rt
    s = idle(); s.exrs = 3; s.exrt = 4; s.memrd = 3; s.memwe = 1; s.wbrd = 4; s.wbwe = 1;
    step("R5", s);
    // R5: both match the same register, MEM wins
    s = idle(); s.exrs = 7; s.exrt = 7; s.memrd = 7; s.memwe = 1; s.wbrd = 7; s.wbwe = 1;
    step("R5", s);
    // R6: register 0 never forwarded, no stall from an r0 producer
    s = idle(); s.br = 1; s.rs = 0; s.rt = 2; s.rsv = 0; s.rtv = 0; s.imm = 3;
    s.memrd = 0; s.memwe = 1; s.memv = 5; s.exrd = 0; s.exwe = 1; s.exrs = 0;
    step("R6", s);
    // R7: load-use stall on a non-branch consumer, PC held (R10)
    s = idle(); s.rs = 8; s.rt = 9; s.exrd = 9; s.exwe = 1; s.exld = 1;
    step("R7", s);
    step("R10", s);
    // R8: branch behind an ALU producer in EX
    s = idle(); s.br = 1; s.rs = 5; s.rt = 6; s.rsv = 3; s.rtv = 3; s.imm = 4;
    s.exrd = 6; s.exwe = 1;
    step("R8", s);
    // producer moves to MEM, forwarded, equal -> taken
    s.exrd = 0; s.exwe = 0; s.memrd = 6; s.memwe = 1; s.memv = 3;
    step("R8", s);
    // R9: load in EX then MEM gives two stalls, then taken from WB
    s = idle(); s.br = 1; s.rs = 5; s.rt = 6; s.rsv = 0; s.rtv = 7; s.imm = 10;
    s.exrd = 5; s.exwe = 1; s.exld = 1;
    step("R9", s);
    s.exrd = 0; s.exwe = 0; s.exld = 0; s.memrd = 5; s.memwe = 1; s.memld = 1;
    step("R9", s);
    s.memrd = 0; s.memwe = 0; s.memld = 0; s.wbrd = 5; s.wbwe = 1; s.wbv = 7;
    step("R9", s);
    // R9: load in MEM with a non-branch consumer does not stall
    s = idle(); s.rs = 5; s.exrs = 5; s.memrd = 5; s.memwe = 1; s.memld = 1;
    step("R9", s);
    step("R1", idle());

    @(posedge clk); #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule